// File: doc/BRIEF.md
# Two-Wire Register Access Slave for a Multi-Port Power Controller

This block lets an external bus master read and write the registers of a multi-port power controller over a two-wire serial bus. The master clocks the bus. Serial data arrives on a dedicated input pin. The slave answers only by pulling a separate open-drain output low, which allows the two data directions to cross an isolation barrier independently. The slave never drives the clock line. Both bus lines are oversampled on the system clock, so start and stop conditions and clock edges are all recognised in the system clock domain.

A transfer begins with an address byte. Its five-bit device field is compared with strap inputs. The next byte is a pointer that chooses one of eight register kinds and one of eight ports. The pointer is placed on a parallel register-file interface. A write transfer then delivers one data byte, which produces a single-cycle write strobe. A read transfer repeats the start and sends the address with the read flag. The slave then shifts out the byte that the register file returns for the current pointer. While supply-good is low, and for a fixed number of clocks after it rises, the whole interface is held cleared.

Top module: `pse_i2c_slave`

## Requirements
- R1: SDA falling while SCL is high is a start and restarts address reception from any state, including partway through a byte. SDA rising while SCL is high is a stop and returns the slave to idle with SDA released.
- R2: In the address byte, bits 7..6 are ignored, bits 5..1 must equal `strap_addr`, and bit 0 is the direction (1 = read). On a match the slave acknowledges.
- R3: After an address mismatch the slave gives no acknowledge and no write strobe, and leaves `rf_addr` unchanged. It ignores every later bit, even a byte that would match, until the next start.
- R4: An acknowledge is given by raising `sda_drive_low` after SCL falls at the end of the eighth bit and releasing it after SCL falls at the end of the ninth. The output changes only after an SCL fall, a start, a stop or a reset, so it is steady while SCL is high.
- R5: Once a matched address has been received, the byte that follows is a pointer. It is always acknowledged, and its bits 5..0 appear on `rf_addr`: bits 5..3 form the register select and bits 2..0 the port (000 = first port). Bits 7..6 are ignored.
- R6: A write is a matched address with direction 0, then a pointer, then a data byte. When the register select is 000 or 010, the data byte causes a `rf_we` pulse exactly one cycle wide with the byte on `rf_wdata`.
- R7: When the register select is 001, 011, 100, 101, 110 or 111, the data byte of a write is acknowledged but produces no `rf_we` pulse.
- R8: A read is a matched address with direction 0, a pointer, a repeated start, and a matched address with direction 1. The slave then drives `rf_rdata` for the current pointer most significant bit first, changing each bit after an SCL fall.
- R9: After the eighth data bit of a read, the slave releases SDA and ignores the master's acknowledge or not-acknowledge bit. It then waits for the next start.
- R10: While `supply_ok` is low, and until it has been high for 8 consecutive clock cycles, the slave is held cleared. It gives no acknowledge and no strobe, and `rf_addr` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supplies good; the interface starts after it has been high for the power-on delay |
| strap_addr | input | 5 | Device address straps |
| scl_i | input | 1 | Bus clock from the master |
| sda_i | input | 1 | Bus data input |
| sda_drive_low | output | 1 | 1 = pull the open-drain data output low |
| rf_addr | output | 6 | Register select (5..3) and port (2..0) from the pointer byte |
| rf_we | output | 1 | One-cycle write strobe |
| rf_wdata | output | 8 | Write data, valid with `rf_we` |
| rf_rdata | input | 8 | Read data for the current `rf_addr` |

## Verification
The hardest situations to reach from the ports are a bus condition that lands in the middle of a byte and a mismatched address followed by bytes that look valid. The bench reaches these with directed sequences. One abandons a pointer byte after four bits with a repeated start, one ends a byte after three bits with a stop, and one sends a matching address pattern after a mismatch without a new start. Random transfers then mix read and write direction, all register selects and ports, random values in the ignored address bits, and occasional wrong device fields. Each outcome is compared against a bench model of the register file.

// File: rtl/pse_i2c_pkg.sv
package pse_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int PORT_W = 3;
  localparam int PTR_W  = SEL_W + PORT_W;

  localparam logic [SEL_W-1:0] SEL_COMMON_CTL = 3'b000;
  localparam logic [SEL_W-1:0] SEL_PORT_CTL   = 3'b010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK
  } bus_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } byte_kind_e;

  function automatic logic sel_writable(input logic [SEL_W-1:0] sel);
    return (sel == SEL_COMMON_CTL) || (sel == SEL_PORT_CTL);
  endfunction
endpackage

// File: rtl/pse_i2c_por_gate.sv
module pse_i2c_por_gate #(
  parameter int DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic active
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(DELAY);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!supply_ok) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_DONE) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign active = (cnt_q == CNT_DONE);
endmodule

// File: rtl/pse_i2c_line_sync.sv
module pse_i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic scl_d, sda_d, scl_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_chain[g] <= 1'b1;
        sda_chain[g] <= 1'b1;
      end else if (g == 0) begin
        scl_chain[g] <= scl_i;
        sda_chain[g] <= sda_i;
      end else begin
        scl_chain[g] <= scl_chain[(g == 0) ? 0 : g-1];
        sda_chain[g] <= sda_chain[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/pse_i2c_xfer_fsm.sv
module pse_i2c_xfer_fsm
  import pse_i2c_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic              sda_pull,
  output logic [PTR_W-1:0]  rf_addr,
  output logic              rf_we,
  output logic [BYTE_W-1:0] rf_wdata
);
  localparam int BCW = $clog2(BYTE_W + 1);
  localparam logic [BCW-1:0] BIT_FULL = BCW'(BYTE_W);
  localparam logic [BCW-1:0] BIT_LAST = BCW'(BYTE_W - 1);

  bus_state_e        state_q, state_d;
  byte_kind_e        kind_q, kind_d;
  logic [BCW-1:0]    bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic              pull_q, pull_d;
  logic              we_q, we_d;
  logic              send_q, send_d;
  logic              addr_hit;

  assign addr_hit = (sh_q[ADDR_W:1] == strap_addr);

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    wdata_d = wdata_q;
    pull_d  = pull_q;
    send_d  = send_q;
    we_d    = 1'b0;
    if (start_det) begin
      state_d = ST_RECV;
      kind_d  = BK_ADDR;
      bit_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_RECV: begin
          if (scl_rise && (bit_q != BIT_FULL)) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            bit_d = bit_q + 1'b1;
          end else if (scl_fall && (bit_q == BIT_FULL)) begin
            bit_d = '0;
            unique case (kind_q)
              BK_ADDR: begin
                if (addr_hit) begin
                  pull_d  = 1'b1;
                  state_d = ST_ACK;
                  send_d  = sh_q[0];
                  if (sh_q[0]) tx_d = rf_rdata;
                end else begin
                  state_d = ST_IDLE;
                end
              end
              BK_PTR: begin
                ptr_d   = sh_q[PTR_W-1:0];
                pull_d  = 1'b1;
                state_d = ST_ACK;
                send_d  = 1'b0;
              end
              default: begin
                wdata_d = sh_q;
                we_d    = sel_writable(ptr_q[PTR_W-1 -: SEL_W]);
                pull_d  = 1'b1;
                state_d = ST_ACK;
                send_d  = 1'b0;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (send_q) begin
              state_d = ST_SEND;
              pull_d  = ~tx_q[BYTE_W-1];
              bit_d   = '0;
            end else begin
              pull_d = 1'b0;
              unique case (kind_q)
                BK_ADDR: begin kind_d = BK_PTR;  state_d = ST_RECV; end
                BK_PTR:  begin kind_d = BK_DATA; state_d = ST_RECV; end
                default: state_d = ST_IDLE;
              endcase
            end
          end
        end
        ST_SEND: begin
          if (scl_fall) begin
            bit_d = bit_q + 1'b1;
            if (bit_q == BIT_LAST) begin
              pull_d  = 1'b0;
              state_d = ST_MACK;
            end else begin
              tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
              pull_d = ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) state_d = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= BK_ADDR;
      bit_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      wdata_q <= '0;
      pull_q  <= 1'b0;
      we_q    <= 1'b0;
      send_q  <= 1'b0;
    end else if (!active) begin
      state_q <= ST_IDLE;
      kind_q  <= BK_ADDR;
      bit_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      wdata_q <= '0;
      pull_q  <= 1'b0;
      we_q    <= 1'b0;
      send_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      wdata_q <= wdata_d;
      pull_q  <= pull_d;
      we_q    <= we_d;
      send_q  <= send_d;
    end
  end

  assign sda_pull = pull_q;
  assign rf_addr  = ptr_q;
  assign rf_we    = we_q;
  assign rf_wdata = wdata_q;
endmodule

// File: rtl/pse_i2c_slave.sv
module pse_i2c_slave
  import pse_i2c_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int POR_DELAY   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low,
  output logic [PTR_W-1:0]  rf_addr,
  output logic              rf_we,
  output logic [BYTE_W-1:0] rf_wdata,
  input  logic [BYTE_W-1:0] rf_rdata
);
  logic core_active;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  pse_i2c_por_gate #(.DELAY(POR_DELAY)) u_por (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .active    (core_active)
  );

  pse_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  pse_i2c_xfer_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (core_active),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .strap_addr (strap_addr),
    .rf_rdata   (rf_rdata),
    .sda_pull   (sda_drive_low),
    .rf_addr    (rf_addr),
    .rf_we      (rf_we),
    .rf_wdata   (rf_wdata)
  );
endmodule

// File: rtl/pse_i2c_slave_chk.sv
module pse_i2c_slave_chk
  import pse_i2c_pkg::*;
#(
  parameter int POR_DELAY = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok,
  input logic             core_active,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_drive_low,
  input logic             rf_we,
  input logic [PTR_W-1:0] rf_addr
);
  localparam int CW = $clog2(POR_DELAY + 1);
  localparam logic [CW-1:0] SUP_DONE = CW'(POR_DELAY);

  logic [CW-1:0] sup_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_cnt <= '0;
    end else if (!supply_ok) begin
      sup_cnt <= '0;
    end else if (sup_cnt != SUP_DONE) begin
      sup_cnt <= sup_cnt + 1'b1;
    end
  end

  assert_ready_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_active == (sup_cnt == SUP_DONE));

  assert_quiet_inactive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !core_active |=> (!sda_drive_low && !rf_we && rf_addr == '0));

  assert_sda_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> $past(scl_fall || start_det || stop_det || !core_active));

  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_drive_low);

  assert_we_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  assert_we_only_writable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_addr[PTR_W-1 -: SEL_W] == 3'b000 || rf_addr[PTR_W-1 -: SEL_W] == 3'b010));
endmodule

bind pse_i2c_slave pse_i2c_slave_chk #(.POR_DELAY(POR_DELAY)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_ok     (supply_ok),
  .core_active   (core_active),
  .scl_fall      (scl_fall),
  .start_det     (start_det),
  .stop_det      (stop_det),
  .sda_drive_low (sda_drive_low),
  .rf_we         (rf_we),
  .rf_addr       (rf_addr)
);

// File: tb/pse_i2c_slave_bench.sv
module pse_i2c_slave_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [4:0] STRAP = 5'b10110;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n, supply_ok, m_scl, m_sda;
  logic sda_drive_low, rf_we;
  logic [5:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  wire  sda_line = m_sda & ~sda_drive_low;

  int n_checks = 0;
  int n_errors = 0;
  int we_cnt = 0;
  logic [5:0] we_addr;
  logic [7:0] we_data;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rf_model(input logic [5:0] a);
    return {a[2:0], a[5:3], 2'b01} ^ 8'hC3;
  endfunction

  function automatic logic writable(input logic [2:0] sel);
    return (sel == 3'b000) || (sel == 3'b010);
  endfunction

  assign rf_rdata = rf_model(rf_addr);

  pse_i2c_slave u_pse_i2c_slave (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .strap_addr    (STRAP),
    .scl_i         (m_scl),
    .sda_i         (sda_line),
    .sda_drive_low (sda_drive_low),
    .rf_addr       (rf_addr),
    .rf_we         (rf_we),
    .rf_wdata      (rf_wdata),
    .rf_rdata      (rf_rdata)
  );

  always @(posedge clk) begin
    if (rf_we) begin
      we_cnt  <= we_cnt + 1;
      we_addr <= rf_addr;
      we_data <= rf_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s1, s2;
    send_bits(b, 8);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(Q/2); s1 = sda_line; wq(Q/2); s2 = sda_line;
    m_scl = 1'b0; wq();
    chk("R4 ninth-clock level steady while SCL high", s1, s2);
    ack = !s1 && !s2;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = {b[6:0], sda_line}; m_scl = 1'b0; wq();
    end
    m_sda = nack; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
    chk("R9 SDA released after read byte", sda_drive_low, 1'b0);
  endtask

  task automatic do_write(input logic [7:0] ab, input logic [7:0] pb, input logic [7:0] db,
                          output logic a1, output logic a2, output logic a3);
    i2c_start();
    send_byte(ab, a1);
    send_byte(pb, a2);
    send_byte(db, a3);
    i2c_stop();
    wq();
  endtask

  task automatic do_read(input logic [7:0] ab, input logic [7:0] pb, input logic [7:0] abr,
                         input logic nack, output logic a1, output logic a2, output logic a3,
                         output logic [7:0] d);
    i2c_start();
    send_byte(ab, a1);
    send_byte(pb, a2);
    i2c_start();
    send_byte(abr, a3);
    recv_byte(d, nack);
    i2c_stop();
    wq();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic a1, a2, a3;
    logic [7:0] d;
    int w0;
    void'($urandom(32'h5EED_2383));
    rst_n = 1'b0; supply_ok = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    wq(5);
    rst_n = 1'b1;
    wq(2);
    chk("R10 reset sda_drive_low", sda_drive_low, 1'b0);
    chk("R10 reset rf_we", rf_we, 1'b0);
    chk("R10 reset rf_addr", rf_addr, 6'h00);

    // R10: supplies not good yet, the slave stays silent
    do_write(8'hAC, 8'hC5, 8'h3C, a1, a2, a3);
    chk("R10 no ack before supply good", {a1, a2, a3}, 3'b000);
    chk("R10 no strobe before supply good", we_cnt, 0);
    chk("R10 pointer held clear", rf_addr, 6'h00);

    supply_ok = 1'b1;
    wq(20);

    // R2 R5 R6: write to select 000, port 5, reserved bits set
    w0 = we_cnt;
    do_write(8'hAC, 8'hC5, 8'hA5, a1, a2, a3);
    chk("R2 address acked with upper bits ignored", {a1, a2, a3}, 3'b111);
    chk("R6 one strobe for writable select", we_cnt - w0, 1);
    chk("R6 write data", we_data, 8'hA5);
    chk("R5 pointer on rf_addr", we_addr, 6'b000101);

    // R7: select 001 is not writable
    w0 = we_cnt;
    do_write(8'h2C, 8'h0B, 8'h77, a1, a2, a3);
    chk("R7 data byte still acked", {a1, a2, a3}, 3'b111);
    chk("R7 no strobe on read-only select", we_cnt - w0, 0);
    chk("R5 pointer 001/011 on rf_addr", rf_addr, 6'b001011);

    // R8 R9: read select 101, port 0
    do_read(8'hAC, 8'h28, 8'h6D, 1'b1, a1, a2, a3, d);
    chk("R8 read acks", {a1, a2, a3}, 3'b111);
    chk("R8 read data", d, rf_model(6'b101000));

    // R3: mismatch, then a matching pattern without a new start
    w0 = we_cnt;
    i2c_start();
    send_byte(8'h2E, a1);
    send_byte(8'hAC, a2);
    send_byte(8'h10, a3);
    i2c_stop();
    wq();
    chk("R3 no ack after mismatch", {a1, a2, a3}, 3'b000);
    chk("R3 no strobe after mismatch", we_cnt - w0, 0);
    chk("R3 pointer unchanged", rf_addr, 6'b101000);

    // R1: stop three bits into a pointer byte, then a clean write
    w0 = we_cnt;
    i2c_start();
    send_byte(8'hAC, a1);
    send_bits(8'h10, 3);
    i2c_stop();
    wq();
    chk("R1 partial byte ended by stop gives no strobe", we_cnt - w0, 0);
    chk("R1 pointer kept after aborted byte", rf_addr, 6'b101000);

    // R1: repeated start four bits into the pointer byte
    i2c_start();
    send_byte(8'hAC, a1);
    send_bits(8'h3F, 4);
    i2c_start();
    send_byte(8'hEC, a1);
    send_byte(8'h16, a2);
    send_byte(8'h5A, a3);
    i2c_stop();
    wq();
    chk("R1 restart mid-byte then write acks", {a1, a2, a3}, 3'b111);
    chk("R1 write after restart strobed", we_cnt - w0, 1);
    chk("R1 write after restart address", we_addr, 6'b010110);
    chk("R1 write after restart data", we_data, 8'h5A);

    // Random mix of reads and writes
    for (int k = 0; k < 40; k++) begin
      logic [7:0] ab, pb, db, abr;
      logic [5:0] prev;
      logic match, rd, nack;
      logic [4:0] dev;
      rd   = 1'($urandom_range(0, 1));
      dev  = ($urandom_range(0, 3) == 0) ? 5'($urandom) : STRAP;
      match = (dev == STRAP);
      pb   = 8'($urandom);
      db   = 8'($urandom);
      nack = 1'($urandom_range(0, 1));
      prev = rf_addr;
      w0   = we_cnt;
      if (rd) begin
        ab  = {2'($urandom), STRAP, 1'b0};
        abr = {2'($urandom), dev, 1'b1};
        do_read(ab, pb, abr, nack, a1, a2, a3, d);
        chk("R5 random read pointer acks", {a1, a2}, 2'b11);
        chk("R2 random read address ack", a3, match);
        chk("R8 random read data", d, match ? rf_model(pb[5:0]) : 8'hFF);
        chk("R5 random read rf_addr", rf_addr, pb[5:0]);
      end else begin
        ab = {2'($urandom), dev, 1'b0};
        do_write(ab, pb, db, a1, a2, a3);
        chk("R2 random write acks", {a1, a2, a3}, {3{match}});
        chk("R6 random write strobes", we_cnt - w0, (match && writable(pb[5:3])) ? 1 : 0);
        chk("R3 random write rf_addr", rf_addr, match ? pb[5:0] : prev);
        if (match && writable(pb[5:3])) chk("R6 random write data", we_data, db);
      end
    end

    // R10: supply loss clears the slave
    supply_ok = 1'b0;
    wq(3);
    chk("R10 pointer cleared on supply loss", rf_addr, 6'h00);
    w0 = we_cnt;
    do_write(8'hAC, 8'h02, 8'h11, a1, a2, a3);
    chk("R10 silent while supply low", {a1, a2, a3}, 3'b000);
    chk("R10 no strobe while supply low", we_cnt - w0, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule